// File: doc/BRIEF.md
# Masked Interrupt Aggregator with GPIO Port

This block gathers sixteen sticky event flags and folds them, through a sixteen-bit enable mask, into one active-high interrupt request. Neighbouring logic raises a flag with a one-cycle pulse on the matching bit of `set_in`. Bits 8, 9 and 10 are meant for a real-time-clock periodic tick, an alarm match and an update error. Bit 11 is also raised internally when a power-button line rises. Software reads the flags and the mask one byte at a time. It clears flags by writing ones to a pair of byte-wide acknowledge locations.

The same register space holds a three-line general-purpose port. It has a direction register, an output latch and an input readback. On lines set as outputs, the readback also shows the latched output value. Activity on the three general-purpose inputs never raises an interrupt. Register reads are combinational on `addr`. Writes take effect at the clock edge on which `wr_en` is high.

Top module: `irq_gpio_agg`

## Requirements
- R1: `irq` is high exactly when some status bit is 1 and its mask bit is 0. It follows a status or mask change in the same cycle the register changes.
- R2: After reset, the registers hold these values: mask 0x0FFF, status 0x0000, direction 0x07, output latch 0, input register 0.
- R3: A write to address 0x0 replaces only mask[7:0], and a write to address 0x1 replaces only mask[15:8]. Both bytes read back at the same addresses.
- R4: A pulse on `set_in[i]` sets status bit i, and the bit stays set until it is acknowledged. Status[7:0] reads at address 0x2 and status[15:8] reads at address 0x3.
- R5: A write to address 0x4 clears each status bit in [7:0] where the written byte has a 1. A write to address 0x5 does the same for [15:8]. Both addresses always read 0.
- R6: If a set pulse and an acknowledge of the same bit happen in the same cycle, the bit ends up set.
- R7: A rising edge on `pwr_btn` sets status bit 11. The edge passes through two synchroniser flops plus an edge register, so the bit appears three clock edges after the input rises. Holding the line high does not set the bit again after it is acknowledged.
- R8: The general-purpose inputs are sampled into a register each cycle. Address 0x7 reads {5'b0, inputs} OR (NOT direction AND {5'b0, output latch}). These inputs never change `irq` or the status bits.
- R9: A direction write at address 0x6 keeps only the bits under 0x67. An output-latch write at address 0x8 keeps bits [2:0]. `gpio_oe` equals NOT direction[2:0], so a direction bit of 0 means output. `gpio_out` equals the output latch AND NOT direction[2:0].
- R10: Addresses 0x9 to 0xF read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| set_in | input | 16 | One-cycle set pulses, one per status bit |
| pwr_btn | input | 1 | Power-button level (asynchronous) |
| gpio_in | input | 3 | General-purpose input levels |
| gpio_out | output | 3 | Output value on lines set as outputs |
| gpio_oe | output | 3 | Output enable per line |
| irq | output | 1 | Aggregated active-high interrupt |

## Verification
The embedded assertions check several properties on every cycle. Set pulses always land in status, and set beats acknowledge. Status bits never drop without an acknowledge write, and an acknowledge leaves no written bit standing unless it is set again. A low-byte mask write keeps the high byte, the power-button edge pulse never lasts two cycles, and the direction register never holds bits outside 0x67. The reset values, the exact three-edge latency of the power button, the no-repeat rule on a held button, the input readback merge and the silence of unmapped addresses are shown only by the bench. The bench compares every output against its behavioural model on each clock, across directed scenarios and a random phase.

// File: rtl/irq_gpio_agg.sv
module irq_gpio_agg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic [15:0] set_in,
  input  logic        pwr_btn,
  input  logic [2:0]  gpio_in,
  output logic [2:0]  gpio_out,
  output logic [2:0]  gpio_oe,
  output logic        irq
);
  localparam logic [3:0] A_MASK_LO = 4'h0;
  localparam logic [3:0] A_MASK_HI = 4'h1;
  localparam logic [3:0] A_STAT_LO = 4'h2;
  localparam logic [3:0] A_STAT_HI = 4'h3;
  localparam logic [3:0] A_ACK_LO  = 4'h4;
  localparam logic [3:0] A_ACK_HI  = 4'h5;
  localparam logic [3:0] A_DIR     = 4'h6;
  localparam logic [3:0] A_GIN     = 4'h7;
  localparam logic [3:0] A_GOUT    = 4'h8;
  localparam logic [7:0] DIR_KEEP  = 8'h67;
  localparam int         BTN_BIT   = 11;

  logic [15:0] mask_q, stat_q, ack_vec, set_vec;
  logic [7:0]  dir_q;
  logic [2:0]  out_q, in_q;
  logic        btn_s1, btn_s2, btn_prev, btn_edge;

  assign btn_edge = btn_s2 & ~btn_prev;
  assign set_vec  = set_in | (16'(btn_edge) << BTN_BIT);
  assign ack_vec  = !wr_en            ? 16'h0 :
                    addr == A_ACK_LO ? {8'h00, wdata} :
                    addr == A_ACK_HI ? {wdata, 8'h00} : 16'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      btn_s1 <= 1'b0; btn_s2 <= 1'b0; btn_prev <= 1'b0;
      in_q   <= '0;
    end else begin
      btn_s1 <= pwr_btn; btn_s2 <= btn_s1; btn_prev <= btn_s2;
      in_q   <= gpio_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 16'h0FFF;
      stat_q <= 16'h0000;
      dir_q  <= 8'h07;
      out_q  <= 3'b000;
    end else begin
      stat_q <= (stat_q & ~ack_vec) | set_vec;
      if (wr_en) begin
        case (addr)
          A_MASK_LO: mask_q[7:0]  <= wdata;
          A_MASK_HI: mask_q[15:8] <= wdata;
          A_DIR:     dir_q        <= wdata & DIR_KEEP;
          A_GOUT:    out_q        <= wdata[2:0];
          default: ;
        endcase
      end
    end
  end

  assign irq      = |(stat_q & ~mask_q);
  assign gpio_oe  = ~dir_q[2:0];
  assign gpio_out = out_q & ~dir_q[2:0];

  always_comb begin
    case (addr)
      A_MASK_LO: rdata = mask_q[7:0];
      A_MASK_HI: rdata = mask_q[15:8];
      A_STAT_LO: rdata = stat_q[7:0];
      A_STAT_HI: rdata = stat_q[15:8];
      A_DIR:     rdata = dir_q;
      A_GIN:     rdata = {5'b0, in_q} | (~dir_q & {5'b0, out_q});
      A_GOUT:    rdata = {5'b0, out_q};
      default:   rdata = 8'h00;
    endcase
  end

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != 16'h0) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

  // R4
  sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == A_ACK_LO || addr == A_ACK_HI)) |=> (($past(stat_q) & ~stat_q) == 16'h0));

  // R5
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_ACK_LO) |=> ((stat_q[7:0] & $past(wdata) & ~$past(set_vec[7:0])) == 8'h0));

  // R3
  mask_hi_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MASK_LO) |=> (mask_q[15:8] == $past(mask_q[15:8])));

  // R7
  btn_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    btn_edge |=> !btn_edge);

  // R9
  dir_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dir_q & ~DIR_KEEP) == 8'h00));
endmodule

// File: tb/tb_irq_gpio_agg.sv
module tb_irq_gpio_agg;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic [15:0] set_in = 16'h0;
  logic        pwr_btn = 1'b0;
  logic [2:0]  gpio_in = 3'b0;
  logic [2:0]  gpio_out, gpio_oe;
  logic        irq;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  // behavioural model state
  int m_mask, m_stat, m_dir, m_out, m_in;
  int btn_hist[$];
  int m_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_gpio_agg dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .set_in(set_in), .pwr_btn(pwr_btn),
    .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq(irq));

  task automatic model_reset();
    m_mask = 'h0FFF; m_stat = 0; m_dir = 'h07; m_out = 0; m_in = 0;
    btn_hist = '{0, 0}; m_prev = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int setv, ackv, a, w, s2;
      a = addr; w = wdata;
      s2 = btn_hist[1];
      setv = set_in | (((s2 != 0) && (m_prev == 0)) ? (1 << 11) : 0);
      ackv = 0;
      if (wr_en && a == 4) ackv = w;
      if (wr_en && a == 5) ackv = w << 8;
      m_stat = ((m_stat & ~ackv) | setv) & 'hFFFF;
      if (wr_en) begin
        if (a == 0) m_mask = (m_mask & 'hFF00) | w;
        if (a == 1) m_mask = (m_mask & 'h00FF) | (w << 8);
        if (a == 6) m_dir  = w & 'h67;
        if (a == 8) m_out  = w & 7;
      end
      m_in = gpio_in;
      m_prev = s2;
      void'(btn_hist.pop_back());
      btn_hist.push_front(int'(pwr_btn));
    end
  end

  function automatic int exp_rd(int a);
    case (a)
      0: return m_mask & 'hFF;
      1: return (m_mask >> 8) & 'hFF;
      2: return m_stat & 'hFF;
      3: return (m_stat >> 8) & 'hFF;
      6: return m_dir;
      7: return (m_in | (~m_dir & m_out)) & 'hFF;
      8: return m_out;
      default: return 0;
    endcase
  endfunction

  function automatic string rd_tag(int a);
    case (a)
      0, 1: return "R3";
      2, 3: return "R4";
      4, 5: return "R5";
      6, 8: return "R9";
      7: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int e_irq;
    e_irq = ((m_stat & ~m_mask & 'hFFFF) != 0) ? 1 : 0;
    chk("R1", "irq", int'(irq), e_irq);
    chk(rd_tag(int'(addr)), "rdata", int'(rdata), exp_rd(int'(addr)));
    chk("R9", "gpio_oe", int'(gpio_oe), (~m_dir) & 7);
    chk("R9", "gpio_out", int'(gpio_out), m_out & ~m_dir & 7);
  endtask

  // drive one cycle: compare at the falling edge, then apply new inputs
  task automatic cyc(bit we, int a, int d, int s = 0);
    @(negedge clk);
    compare_all();
    wr_en = we; addr = 4'(a); wdata = 8'(d); set_in = 16'(s);
  endtask

  task automatic rd(int a);
    cyc(0, a, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2: reset values through every address
    for (int a = 0; a < 16; a++) rd(a);
    // R3: byte-wise mask writes
    cyc(1, 0, 'h00); rd(1); rd(0);
    cyc(1, 1, 'hA5); rd(0); rd(1);
    // R4 / R1: set pulses, sticky, irq follows mask
    cyc(0, 2, 0, 'h0008); rd(2); rd(2);
    cyc(1, 0, 'h08); rd(2);
    cyc(1, 0, 'h00); rd(3);
    cyc(0, 3, 0, 'h0300); rd(3);
    // R5: acknowledge, ack addresses read zero
    rd(4); rd(5);
    cyc(1, 4, 'h08); rd(2);
    cyc(1, 5, 'h01); rd(3);
    cyc(1, 5, 'hFF); rd(3);
    // R6: set and ack of same bit in one cycle
    cyc(1, 4, 'h10, 'h0010); rd(2);
    cyc(1, 4, 'hFF); rd(2);
    // R7: power button edge, held level, ack while held
    cyc(1, 1, 'h00);
    @(negedge clk); compare_all(); pwr_btn = 1'b1; wr_en = 0; addr = 4'h3;
    repeat (6) rd(3);
    cyc(1, 5, 'h08);
    repeat (6) rd(3);
    @(negedge clk); compare_all(); pwr_btn = 1'b0;
    repeat (4) rd(3);
    @(negedge clk); compare_all(); pwr_btn = 1'b1;
    repeat (5) rd(3);
    cyc(1, 5, 'hFF);
    // R8: inputs never interrupt, readback merge
    cyc(1, 0, 'h00); cyc(1, 1, 'h00);
    for (int v = 0; v < 8; v++) begin
      @(negedge clk); compare_all(); gpio_in = 3'(v); wr_en = 0; addr = 4'h7;
      rd(7);
    end
    // R9: direction and output latch
    cyc(1, 6, 'hFF); rd(6);
    cyc(1, 6, 'h02); rd(6);
    cyc(1, 8, 'hFD); rd(8); rd(7);
    gpio_in = 3'b000; rd(7); rd(7);
    // R10: unmapped addresses
    for (int a = 9; a < 16; a++) begin cyc(1, a, 'hFF); rd(a); end
    for (int a = 0; a < 9; a++) rd(a);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      @(negedge clk); compare_all();
      wr_en   = r[0];
      addr    = 4'($urandom_range(0, 10));
      wdata   = 8'($urandom);
      set_in  = (r[3:1] == 0) ? 16'(1 << $urandom_range(0, 15)) : 16'h0;
      gpio_in = r[6:4];
      if (r[12:7] == 0) pwr_btn = ~pwr_btn;
    end
    // reset in mid-run, R2 again
    @(negedge clk); compare_all(); rst_n = 1'b0; wr_en = 0;
    @(negedge clk); rst_n = 1'b1;
    for (int a = 0; a < 9; a++) rd(a);
    @(negedge clk); compare_all();
    finish_run();
  end
endmodule